// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers the event sources of a storage socket controller into a local status register. Each local bit latches when its source pulses for one cycle, and software clears it by writing 1. A local enable register picks which pending bits count toward the controller's summary. The summary then sets bit 0 of a global status register. The global register is shared with a second peripheral, which owns bit 1 and sets it from its own pulse input.

The global level has two masks. A status-enable mask decides whether a global bit may latch at all. A signal-enable mask decides whether a latched and status-enabled bit drives the single interrupt line. The line is registered.

Software reaches all five registers through a plain 32-bit register port: write strobe, word address, write data, and combinational read data. The port has no handshake and no back-pressure. A write takes effect at the clock edge on which the strobe is high. Read data follows the address in the same cycle. The event inputs are plain one-cycle pulses with no valid/ready pairing, because they carry no payload.

Top module: `irq_agg_top`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A pulse on `src_evt[i]` sets local status bit i at the next edge whatever the local enable holds, for the implemented bits i in {0,1,2,3,8,9,10,11}; pulses on bits 4 to 7 are ignored and those bits read 0.
- R3: A write to the local status register (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged.
- R4: When an event pulse and a clearing write hit the same local bit in the same cycle, the bit stays set.
- R5: The local enable register (address 1) stores written data only in the implemented bit positions; the other bits read 0.
- R6: Global status bit 0 (address 2) sets at the edge after a cycle in which some local bit is both pending and enabled while status-enable bit 0 is 1; pending local bits that are not enabled do not set it.
- R7: A pulse on `peer_evt` sets global status bit 1 at the next edge while status-enable bit 1 is 1.
- R8: Writing 1 to a global status bit clears it; if its set condition holds in the same cycle, the bit stays set.
- R9: A global status bit whose status-enable bit is 0 does not latch; status-enable is at address 3 and signal-enable at address 4, both using bits [1:0] only.
- R10: `irq_o` equals, one cycle later, the OR over both global bits of status AND status-enable AND signal-enable.
- R11: Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| src_evt | input | 12 | One-cycle event pulses from the local sources |
| peer_evt | input | 1 | One-cycle event pulse from the sharing peripheral |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The bench targets four corner cases:
- A pulse and a clear on the same cycle. A design that gives the clear priority would drop that event.
- Pending local bits whose enable is off. A design that folds raw status into the summary would raise global bit 0 early.
- A global clear while the local summary is still active. The bit must come straight back, or a pending source goes unreported.
- Toggling each global mask separately. This exposes a design that drops the latch gate, or ties the line to only one of the masks or only one peripheral.

Random traffic across all addresses also covers writes to unmapped addresses and pulses on unimplemented bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int LOC_W  = 12;
  localparam int GLB_W  = 2;
  localparam int ADDR_W = 3;
  localparam logic [LOC_W-1:0] LOC_IMPL = 12'hF0F;
  localparam logic [GLB_W-1:0] GLB_IMPL = 2'b11;

  typedef enum logic [ADDR_W-1:0] {
    A_LSTS = 3'd0,
    A_LEN  = 3'd1,
    A_GSTS = 3'd2,
    A_GSEN = 3'd3,
    A_GSIG = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int W = 12,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_q <= 1'b0;
        else if (set_i[i]) bit_q <= 1'b1;
        else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign q_o[i] = bit_q;
    end else begin : g_tie
      assign q_o[i] = 1'b0;
    end
  end

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  // R3
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & IMPL)) |=> ((q_o & $past(clr_i & ~set_i & IMPL)) == '0));
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOC_W-1:0]  lsts_i,
  input  logic [LOC_W-1:0]  len_i,
  input  logic [GLB_W-1:0]  gsts_i,
  input  logic [GLB_W-1:0]  gsen_i,
  input  logic [GLB_W-1:0]  gsig_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_LSTS:  rdata_o[LOC_W-1:0] = lsts_i;
      A_LEN:   rdata_o[LOC_W-1:0] = len_i;
      A_GSTS:  rdata_o[GLB_W-1:0] = gsts_i;
      A_GSEN:  rdata_o[GLB_W-1:0] = gsen_i;
      A_GSIG:  rdata_o[GLB_W-1:0] = gsig_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top
  import irq_agg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [LOC_W-1:0]  src_evt,
  input  logic              peer_evt,
  output logic              irq_o
);
  logic [LOC_W-1:0] lsts, len_q, lclr;
  logic [GLB_W-1:0] gsts, gsen_q, gsig_q, gset, gclr;
  logic             loc_any;
  logic             irq_q;

  // Write decode
  assign lclr = (reg_we && reg_addr == A_LSTS) ? reg_wdata[LOC_W-1:0] : '0;
  assign gclr = (reg_we && reg_addr == A_GSTS) ? reg_wdata[GLB_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      gsen_q <= '0;
      gsig_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_LEN)  len_q  <= reg_wdata[LOC_W-1:0] & LOC_IMPL;
      if (reg_addr == A_GSEN) gsen_q <= reg_wdata[GLB_W-1:0];
      if (reg_addr == A_GSIG) gsig_q <= reg_wdata[GLB_W-1:0];
    end
  end

  irq_w1c_bank #(.W(LOC_W), .IMPL(LOC_IMPL)) u_local (
    .clk(clk), .rst_n(rst_n), .set_i(src_evt), .clr_i(lclr), .q_o(lsts)
  );

  assign loc_any = |(lsts & len_q);
  assign gset    = {peer_evt, loc_any} & gsen_q;

  irq_w1c_bank #(.W(GLB_W), .IMPL(GLB_IMPL)) u_global (
    .clk(clk), .rst_n(rst_n), .set_i(gset), .clr_i(gclr), .q_o(gsts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(gsts & gsen_q & gsig_q);
  end
  assign irq_o = irq_q;

  irq_agg_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .addr_i(reg_addr), .lsts_i(lsts), .len_i(len_q),
    .gsts_i(gsts), .gsen_i(gsen_q), .gsig_i(gsig_q), .rdata_o(reg_rdata)
  );

  // R6
  glb_local_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lsts & len_q) && gsen_q[0]) |=> gsts[0]);

  // R7
  glb_peer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_evt && gsen_q[1]) |=> gsts[1]);

  // R9
  glb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gsen_q[1] && !gsts[1]) |=> !gsts[1]);

  // R10
  irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(gsts & gsen_q & gsig_q))));
endmodule

// File: tb/tb_irq_agg_top.sv
module tb_irq_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] src_evt = '0;
  logic        peer_evt = 1'b0;
  logic        irq_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // Behavioural reference state
  logic [11:0] m_ls = '0, m_le = '0;
  logic [1:0]  m_gs = '0, m_gen = '0, m_gsg = '0;
  logic        m_irq = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_agg_top dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_evt(src_evt),
    .peer_evt(peer_evt), .irq_o(irq_o)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return {20'd0, m_ls};
      3'd1: return {20'd0, m_le};
      3'd2: return {30'd0, m_gs};
      3'd3: return {30'd0, m_gen};
      3'd4: return {30'd0, m_gsg};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R2/R3/R4";
      3'd1: return "R5";
      3'd2: return "R6/R7/R8/R9";
      3'd3: return "R9";
      3'd4: return "R9";
      default: return "R11";
    endcase
  endfunction

  // Reference model update and per-cycle comparison
  always @(posedge clk) begin
    logic [11:0] lclr;
    logic [1:0]  gclr, gset;
    logic        nirq;
    if (!rst_n) begin
      m_ls = '0; m_le = '0; m_gs = '0; m_gen = '0; m_gsg = '0; m_irq = 1'b0;
    end else begin
      lclr = (reg_we && reg_addr == 3'd0) ? reg_wdata[11:0] : 12'd0;
      gclr = (reg_we && reg_addr == 3'd2) ? reg_wdata[1:0] : 2'd0;
      gset[0] = ((m_ls & m_le) != 0) && m_gen[0];
      gset[1] = peer_evt && m_gen[1];
      nirq = ((m_gs & m_gen & m_gsg) != 0);
      m_ls = (m_ls & ~lclr) | (src_evt & 12'hF0F);
      m_gs = (m_gs & ~gclr) | gset;
      m_irq = nirq;
      if (reg_we && reg_addr == 3'd1) m_le  = reg_wdata[11:0] & 12'hF0F;
      if (reg_we && reg_addr == 3'd3) m_gen = reg_wdata[1:0];
      if (reg_we && reg_addr == 3'd4) m_gsg = reg_wdata[1:0];
    end
    #2;
    if (!done) begin
      vectors++;
      if (irq_o !== m_irq) begin
        errors++;
        $display("FAIL R10 irq_o actual=%0b expected=%0b at %0t", irq_o, m_irq, $time);
      end
      vectors++;
      if (reg_rdata !== exp_read(reg_addr)) begin
        errors++;
        $display("FAIL %s addr=%0d rdata actual=%h expected=%h at %0t",
                 tag_of(reg_addr), reg_addr, reg_rdata, exp_read(reg_addr), $time);
      end
    end
  end

  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [11:0] ev, input logic pe);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; src_evt = ev; peer_evt = pe;
  endtask

  task automatic rd(input logic [2:0] a);
    step(1'b0, a, 32'd0, 12'd0, 1'b0);
  endtask

  task automatic direct_check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    direct_check("R1 irq", {31'd0, irq_o}, 32'd0);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0]);
      @(posedge clk); #3;
      direct_check("R1 read", reg_rdata, 32'd0);
    end
    // R2: events latch with enable off, bits 4..7 ignored
    step(1'b0, 3'd0, 32'd0, 12'h0F1, 1'b0);
    rd(3'd0);
    @(posedge clk); #3;
    direct_check("R2 latch", reg_rdata, 32'h001);
    // R5: enable stores implemented bits only
    step(1'b1, 3'd1, 32'hFFFF_FFFF, 12'd0, 1'b0);
    rd(3'd1);
    @(posedge clk); #3;
    direct_check("R5 enable", reg_rdata, 32'hF0F);
    step(1'b1, 3'd1, 32'd0, 12'd0, 1'b0);
    // R9: global bit does not latch without status-enable
    rd(3'd2); rd(3'd2);
    @(posedge clk); #3;
    direct_check("R9 gate", reg_rdata, 32'd0);
    step(1'b1, 3'd3, 32'd3, 12'd0, 1'b0);
    // R6: pending but disabled local bit keeps global bit 0 clear
    rd(3'd2); rd(3'd2);
    @(posedge clk); #3;
    direct_check("R6 disabled", reg_rdata, 32'd0);
    step(1'b1, 3'd1, 32'h001, 12'd0, 1'b0);
    rd(3'd2); rd(3'd2);
    @(posedge clk); #3;
    direct_check("R6 set", reg_rdata, 32'd1);
    // R8: clear while still pending re-sets
    step(1'b1, 3'd2, 32'd1, 12'd0, 1'b0);
    rd(3'd2);
    @(posedge clk); #3;
    direct_check("R8 resets", reg_rdata, 32'd1);
    // R3: W1C local, zeros leave bits
    step(1'b0, 3'd0, 32'd0, 12'hE00, 1'b0);
    step(1'b1, 3'd0, 32'h201, 12'd0, 1'b0);
    rd(3'd0);
    @(posedge clk); #3;
    direct_check("R3 w1c", reg_rdata, 32'hC00);
    // R4: event and clear in same cycle
    step(1'b1, 3'd0, 32'h400, 12'h400, 1'b0);
    rd(3'd0);
    @(posedge clk); #3;
    direct_check("R4 set wins", reg_rdata, 32'hC00);
    step(1'b1, 3'd0, 32'hFFF, 12'd0, 1'b0);
    step(1'b1, 3'd2, 32'd3, 12'd0, 1'b0);
    // R7 and R10: peer event, signal-enable gating
    step(1'b0, 3'd2, 32'd0, 12'd0, 1'b1);
    rd(3'd2); rd(3'd2);
    @(posedge clk); #3;
    direct_check("R7 peer", reg_rdata, 32'd2);
    direct_check("R10 masked", {31'd0, irq_o}, 32'd0);
    step(1'b1, 3'd4, 32'd2, 12'd0, 1'b0);
    rd(3'd4); rd(3'd4);
    @(posedge clk); #3;
    direct_check("R10 line", {31'd0, irq_o}, 32'd1);
    // R11: unmapped writes ignored
    step(1'b1, 3'd6, 32'hFFFF_FFFF, 12'd0, 1'b0);
    rd(3'd4);
    @(posedge clk); #3;
    direct_check("R11 unmapped", reg_rdata, 32'd2);
    // Random traffic compared every cycle against the model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] & r[1], r[4:2], $urandom,
           (r[7:5] == 3'd0) ? 12'($urandom) : 12'd0, r[10:8] == 3'd0);
    end
    rd(3'd0);
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule